// File: doc/BRIEF.md
# Multi-Mode Serial Port Core

This block is a byte-wide serial port that runs in one of four modes. Mode 0 is a synchronous shift mode: it drives a shift clock and moves eight bits out on the data line while taking eight bits in. Mode 1 is an 8-bit asynchronous mode. Modes 2 and 3 are 9-bit asynchronous modes. Mode 2 runs from the core clock at a fixed rate, and mode 3 runs from a selectable rate. A host reaches three byte registers through a plain register interface: control, status and data. Writing the data register starts a transmission. Reading it returns the last byte received.

Each direction takes its baud tick from its own 2-bit selector, which picks one of four external overflow inputs. That tick is halved unless the full-rate bit is set. In the asynchronous modes the tick is the 16x oversampling clock, so one bit lasts 16 ticks. The host can filter multiprocessor traffic. A separate address filter supplies a match input, and the core combines it with the received ninth bit. The interrupt request is the OR of the two completion flags.

Top module: `sport_core`

## Requirements
- R1: After reset every bit of the control (address 0) and status (address 1) registers reads 0. The receive buffer (address 2) reads 0, `txd_o` and `sclk_o` are 1, and `irq_o` is 0.
- R2: Control bits [1:0] are the mode: 00 synchronous, 01 8-bit asynchronous, 10 9-bit fixed rate, 11 9-bit selectable rate. The field reads back as written. Control also holds: bit 2 filter enable, bit 3 receive enable, bit 4 transmit ninth bit, bit 5 receive ninth bit, bit 6 transmit done, bit 7 receive done.
- R3: In mode 01 a data write sends a 0 start bit, then 8 data bits LSB first, then a 1 stop bit, each 16 baud ticks long. Transmit done sets on the clock edge that begins the stop bit.
- R4: In modes 10 and 11 the frame carries a ninth bit after the data, taken from control bit 4. A received ninth bit is stored in control bit 5.
- R5: Mode 10 ignores the overflow inputs. A bit lasts 16 core clocks when status bit 4 is 1 and 32 core clocks when it is 0.
- R6: Status [1:0] selects the transmit tick source and status [3:2] selects the receive tick source, each as `ovf_i[sel]`. The selected tick is halved unless status bit 4 (full rate) is 1.
- R7: In mode 01 with the filter bit clear, the received stop level goes to control bit 5 and the byte is accepted. With the filter bit set, a byte is accepted only if its stop bit is 1. A 0 stop bit always sets the frame error flag, status bit 7.
- R8: In modes 10 and 11 with the filter bit set, a byte is accepted only when its ninth bit is 1 and `addr_match_i` is 1 at the end of the frame.
- R9: The receiver ignores the line while receive enable (control bit 3) is 0. Neither receive done nor the buffer changes.
- R10: When a byte is accepted before the previous one was read from address 2, the overrun flag (status bit 6) sets and the new byte replaces the old one.
- R11: A data write while a transmission is in progress sets the collision flag (status bit 5). That write does not alter or restart the frame.
- R12: Hardware only sets the transmit-done and receive-done flags, and only a host write clears them. `irq_o` is 1 exactly when either flag is 1.
- R13: In mode 00 a data write shifts 8 bits LSB first on `txd_o`. Each bit takes one tick with `sclk_o` low and then one tick with `sclk_o` high. `rxd_i` is sampled as `sclk_o` rises. Transmit done sets after the 8th bit. If receive enable is 1, the sampled byte is loaded into the buffer and receive done sets.
- R14: The asynchronous receiver takes a majority vote of three samples near mid-bit. It drops a start bit whose vote at mid-bit is high, and a single-tick glitch at a sample point does not change a received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe (marks a data-register read) |
| rdata_o | output | 8 | Read data for `addr_i` |
| ovf_i | input | 4 | External timer overflow ticks |
| addr_match_i | input | 1 | Verdict from the external address filter |
| rxd_i | input | 1 | Serial data in |
| txd_o | output | 1 | Serial data out |
| sclk_o | output | 1 | Shift clock for the synchronous mode |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures the exact edge at which transmit done rises. A core that raised it at the end of the stop bit, or one bit early, fails that check. It sends bad frames: a low stop bit with and without the filter bit, and 9-bit frames with and without a ninth bit or an address match. A wrong acceptance rule then shows up either as a receive-done flag that should not be there or as a missing frame error. A second data write during a frame must leave exactly one frame on the line. A core that restarted or queued the write would put a second frame on the line, and the scoreboard would flag it. The bench also sends a short start pulse and glitched data bits, which catch a receiver that samples once instead of voting. In the synchronous mode the bench checks the shift clock phase and the data on every bit.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC   = 2'b00,
    MODE_ASYNC8 = 2'b01,
    MODE_FIX9   = 2'b10,
    MODE_VAR9   = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/sport_baud.sv
module sport_baud #(
  parameter int NSRC = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            fixed_i,
  input  logic            full_i,
  output logic            tick_o
);
  logic raw, half_q;

  // fixed rate runs from the core clock
  assign raw    = fixed_i | src_i[sel_i];
  assign tick_o = raw & (full_i | half_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)  half_q <= 1'b0;
    else if (raw) half_q <= ~half_q;

  // R6
  tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (fixed_i || src_i[sel_i]));
endmodule

// File: rtl/sport_tx.sv
module sport_tx import sport_pkg::*; #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  mode_e         mode_i,
  input  logic [DW-1:0] data_i,
  input  logic          bit9_i,
  input  logic          rxd_i,
  output logic          txd_o,
  output logic          sclk_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rbyte_o
);
  localparam int SW = $clog2(OSR);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);

  mode_e         mode_q;
  logic [FW-1:0] sh_q;
  logic [SW-1:0] sub_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, sclk_q;
  logic [DW-1:0] rin_q;
  logic          sync_m, sub_end;
  logic [CW-1:0] stop_idx;

  assign sync_m   = (mode_q == MODE_SYNC);
  assign sub_end  = (sub_q == SW'(OSR - 1));
  assign stop_idx = (mode_q == MODE_ASYNC8) ? CW'(DW + 1) : CW'(DW + 2);
  // async: done as the stop bit begins; sync: after the last high phase
  assign done_o   = busy_q && tick_i &&
                    (sync_m ? (sclk_q && cnt_q == CW'(DW - 1))
                            : (sub_end && cnt_q == stop_idx - 1'b1));
  assign txd_o    = busy_q ? sh_q[0] : 1'b1;
  assign sclk_o   = sclk_q;
  assign busy_o   = busy_q;
  assign rbyte_o  = rin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SYNC;
      sh_q   <= '1;
      sub_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      rin_q  <= '0;
    end else if (start_i) begin
      mode_q <= mode_i;
      busy_q <= 1'b1;
      sub_q  <= '0;
      cnt_q  <= '0;
      if (mode_i == MODE_SYNC) begin
        sh_q   <= {{(FW-DW){1'b1}}, data_i};
        sclk_q <= 1'b0;
      end else if (mode_i == MODE_ASYNC8) begin
        sh_q <= {2'b11, data_i, 1'b0};
      end else begin
        sh_q <= {1'b1, bit9_i, data_i, 1'b0};
      end
    end else if (busy_q && tick_i) begin
      if (sync_m) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rin_q  <= {rxd_i, rin_q[DW-1:1]};
        end else if (cnt_q == CW'(DW - 1)) begin
          busy_q <= 1'b0;
        end else begin
          sh_q   <= {1'b1, sh_q[FW-1:1]};
          cnt_q  <= cnt_q + 1'b1;
          sclk_q <= 1'b0;
        end
      end else begin
        sub_q <= sub_q + 1'b1;
        if (sub_end) begin
          if (cnt_q == stop_idx) busy_q <= 1'b0;
          else begin
            sh_q  <= {1'b1, sh_q[FW-1:1]};
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  // R13
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sclk_q);
  // R11
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          nine_i,
  input  logic          rxd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          stop_o
);
  localparam int SW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int CW  = $clog2(DW + 2);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  rx_st_e        st_q;
  logic          s1_q, rx_q;
  logic [SW-1:0] sub_q;
  logic [CW-1:0] cnt_q, last;
  logic [1:0]    smp_q;
  logic [DW:0]   sh_q;
  logic          vote, at_vote, sub_end;

  assign vote    = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_q) | (smp_q[1] & rx_q);
  assign at_vote = (sub_q == SW'(MID + 1));
  assign sub_end = (sub_q == SW'(OSR - 1));
  assign last    = nine_i ? CW'(DW) : CW'(DW - 1);
  assign done_o  = en_i && tick_i && st_q == RX_STOP && at_vote;
  assign stop_o  = vote;
  assign data_o  = nine_i ? sh_q[DW-1:0] : sh_q[DW:1];
  assign bit9_o  = sh_q[DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b1;
      rx_q  <= 1'b1;
      st_q  <= RX_IDLE;
      sub_q <= '0;
      cnt_q <= '0;
      smp_q <= '0;
      sh_q  <= '0;
    end else begin
      s1_q <= rxd_i;
      rx_q <= s1_q;
      if (!en_i) begin
        st_q  <= RX_IDLE;
        sub_q <= '0;
      end else if (tick_i) begin
        if (st_q == RX_IDLE) begin
          if (!rx_q) begin
            st_q  <= RX_START;
            sub_q <= SW'(1);
          end
        end else begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == SW'(MID - 1)) smp_q[0] <= rx_q;
          if (sub_q == SW'(MID))     smp_q[1] <= rx_q;
          if (at_vote) begin
            case (st_q)
              RX_START: if (vote) st_q <= RX_IDLE;   // false start
              RX_DATA:  sh_q <= {vote, sh_q[DW:1]};
              RX_STOP:  st_q <= RX_IDLE;
              default:  ;
            endcase
          end
          if (sub_end) begin
            case (st_q)
              RX_START: begin st_q <= RX_DATA; cnt_q <= '0; end
              RX_DATA:  if (cnt_q == last) st_q <= RX_STOP;
                        else cnt_q <= cnt_q + 1'b1;
              default:  ;
            endcase
          end
        end
      end
    end
  end

  // R9
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == RX_IDLE));
endmodule

// File: rtl/sport_core.sv
module sport_core import sport_pkg::*; #(
  parameter int DW   = 8,
  parameter int OSR  = 16,
  parameter int NSRC = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      addr_i,
  input  logic            wr_en_i,
  input  logic [7:0]      wdata_i,
  input  logic            rd_en_i,
  output logic [7:0]      rdata_o,
  input  logic [NSRC-1:0] ovf_i,
  input  logic            addr_match_i,
  input  logic            rxd_i,
  output logic            txd_o,
  output logic            sclk_o,
  output logic            irq_o
);
  mode_e         mode_q;
  logic          mp_q, ren_q, tb9_q, rb9_q, ti_q, ri_q;
  logic [SELW-1:0] tsrc_q, rsrc_q;
  logic          full_q, col_q, ovr_q, fe_q, unread_q;
  logic [DW-1:0] rbuf_q;

  logic wr_ctrl, wr_stat, wr_data, rd_data;
  logic tx_tick, rx_tick, tx_busy, tx_done, tx_start;
  logic rx_done, rx_b9, rx_stop, rx_en, fixed_m;
  logic [DW-1:0] tx_rbyte, rx_data;
  logic accept_async, take_sync, take;
  logic [DW-1:0] take_byte;

  assign wr_ctrl  = wr_en_i && addr_i == ADDR_CTRL;
  assign wr_stat  = wr_en_i && addr_i == ADDR_STAT;
  assign wr_data  = wr_en_i && addr_i == ADDR_DATA;
  assign rd_data  = rd_en_i && addr_i == ADDR_DATA;
  assign tx_start = wr_data && !tx_busy;
  assign fixed_m  = (mode_q == MODE_FIX9);
  assign rx_en    = ren_q && mode_q != MODE_SYNC;

  sport_baud #(.NSRC(NSRC)) u_tx_baud (
    .clk_i, .rst_ni, .src_i(ovf_i), .sel_i(tsrc_q), .fixed_i(fixed_m),
    .full_i(full_q), .tick_o(tx_tick));

  sport_baud #(.NSRC(NSRC)) u_rx_baud (
    .clk_i, .rst_ni, .src_i(ovf_i), .sel_i(rsrc_q), .fixed_i(fixed_m),
    .full_i(full_q), .tick_o(rx_tick));

  sport_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk_i, .rst_ni, .tick_i(tx_tick), .start_i(tx_start), .mode_i(mode_q),
    .data_i(wdata_i[DW-1:0]), .bit9_i(tb9_q), .rxd_i, .txd_o, .sclk_o,
    .busy_o(tx_busy), .done_o(tx_done), .rbyte_o(tx_rbyte));

  sport_rx #(.OSR(OSR), .DW(DW)) u_rx (
    .clk_i, .rst_ni, .en_i(rx_en), .tick_i(rx_tick),
    .nine_i(mode_q[1]), .rxd_i, .done_o(rx_done), .data_o(rx_data),
    .bit9_o(rx_b9), .stop_o(rx_stop));

  // acceptance filter
  always_comb begin
    if (mode_q == MODE_ASYNC8) accept_async = rx_done && (!mp_q || rx_stop);
    else accept_async = rx_done && (!mp_q || (rx_b9 && addr_match_i));
  end
  assign take_sync = tx_done && mode_q == MODE_SYNC && ren_q;
  assign take      = accept_async || take_sync;
  assign take_byte = take_sync ? tx_rbyte : rx_data;
  assign irq_o     = ti_q | ri_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SYNC;
      {mp_q, ren_q, tb9_q, rb9_q, ti_q, ri_q} <= '0;
      tsrc_q <= '0;
      rsrc_q <= '0;
      {full_q, col_q, ovr_q, fe_q} <= '0;
      unread_q <= 1'b0;
      rbuf_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= mode_e'(wdata_i[1:0]);
        mp_q   <= wdata_i[2];
        ren_q  <= wdata_i[3];
        tb9_q  <= wdata_i[4];
        rb9_q  <= wdata_i[5];
        ti_q   <= wdata_i[6];
        ri_q   <= wdata_i[7];
      end
      if (wr_stat) begin
        tsrc_q <= wdata_i[SELW-1:0];
        rsrc_q <= wdata_i[2*SELW-1:SELW];
        full_q <= wdata_i[4];
        col_q  <= wdata_i[5];
        ovr_q  <= wdata_i[6];
        fe_q   <= wdata_i[7];
      end
      if (tx_done) ti_q <= 1'b1;
      if (wr_data && tx_busy) col_q <= 1'b1;
      if (rx_done && !rx_stop) fe_q <= 1'b1;
      if (accept_async) rb9_q <= (mode_q == MODE_ASYNC8) ? rx_stop : rx_b9;
      if (take) begin
        ri_q     <= 1'b1;
        rbuf_q   <= take_byte;
        unread_q <= 1'b1;
        if (unread_q) ovr_q <= 1'b1;
      end else if (rd_data) begin
        unread_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = {ri_q, ti_q, rb9_q, tb9_q, ren_q, mp_q, mode_q};
      ADDR_STAT: rdata_o = {fe_q, ovr_q, col_q, full_q, rsrc_q, tsrc_q};
      ADDR_DATA: rdata_o = 8'(rbuf_q);
      default:   rdata_o = '0;
    endcase
  end

  // R12
  ti_sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ti_q) |-> $past(wr_ctrl));
  // R12
  ri_sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ri_q) |-> $past(wr_ctrl));
  // R3
  ti_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ti_q) |-> ($past(tx_busy) || $past(wr_ctrl)));
  // R11
  col_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && tx_busy) |=> col_q);
endmodule

// File: tb/tb_sport_core.sv
module tb_sport_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, match = 1'b0, rxd = 1'b1;
  logic [7:0] wdata = '0, rdata;
  logic [3:0] ovf = '0;
  logic txd, sclk, irq;

  int n_chk = 0, n_err = 0, cyc = 0, bit_clks = 16;
  int per[4] = '{1, 0, 0, 0};
  bit mon_on = 1'b1, done_flag = 1'b0;
  logic [9:0] exp_q[$];   // {has_ninth, ninth, data}

  sport_core dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .ovf_i(ovf), .addr_match_i(match),
    .rxd_i(rxd), .txd_o(txd), .sclk_o(sclk), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 4; k++) ovf[k] <= (per[k] != 0) && (cyc % (per[k] == 0 ? 1 : per[k]) == 0);
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send(logic [7:0] d, bit nine, bit b9, bit stp, int glitch);
    logic lv[11];
    int n;
    lv[0] = 1'b0;
    for (int i = 0; i < 8; i++) lv[i+1] = d[i];
    n = 9;
    if (nine) begin lv[n] = b9; n++; end
    lv[n] = stp; n++;
    for (int i = 0; i < n; i++) begin
      rxd = lv[i];
      if (i == glitch) begin
        repeat (8) @(negedge clk);
        rxd = ~lv[i];
        @(negedge clk);
        rxd = lv[i];
        repeat (bit_clks - 9) @(negedge clk);
      end else repeat (bit_clks) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic tx_byte(logic [7:0] d, bit nine, bit b9);
    exp_q.push_back({nine, b9, d});
    wr(2'd2, d);
    repeat (13 * bit_clks + 10) @(negedge clk);
  endtask

  // transmit scoreboard monitor
  initial begin : mon
    logic prev, s0, sp, b9;
    logic [7:0] d;
    logic [9:0] e;
    int bc;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_on && prev && !txd) begin
        bc = bit_clks;
        if (exp_q.size() == 0) begin
          chk("R11 unexpected frame", 1, 0);
          e = '0;
        end else e = exp_q.pop_front();
        repeat (bc / 2) @(negedge clk); s0 = txd;
        for (int i = 0; i < 8; i++) begin repeat (bc) @(negedge clk); d[i] = txd; end
        b9 = 1'b0;
        if (e[9]) begin repeat (bc) @(negedge clk); b9 = txd; end
        repeat (bc) @(negedge clk); sp = txd;
        chk("R3 start bit", s0, 0);
        chk(e[9] ? "R4 data" : "R3 data", d, e[7:0]);
        if (e[9]) chk("R4 ninth bit", b9, e[8]);
        chk("R3 stop bit", sp, 1);
      end
      prev = txd;
    end
  end

  initial begin : wdog
    repeat (150000) @(posedge clk);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] txb, rxb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 stat", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 txd", txd, 1); chk("R1 sclk", sclk, 1); chk("R1 irq", irq, 0);

    // R2 mode readback
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, 8'(m)); rd(2'd0, v); chk("R2 mode", v[1:0], m);
    end

    // R3 8-bit frames, done timing
    wr(2'd1, 8'h10); wr(2'd0, 8'h01);
    exp_q.push_back({2'b00, 8'hA5});
    wr(2'd2, 8'hA5);
    repeat (143) @(negedge clk);
    chk("R3 done before stop", irq, 0);
    @(negedge clk);
    chk("R3 done at stop", irq, 1); chk("R3 line at stop", txd, 1);
    repeat (40) @(negedge clk);
    wr(2'd0, 8'h01); chk("R12 sw clear irq", irq, 0);
    tx_byte(8'h3C, 0, 0);

    // R4 9-bit selectable-rate frames
    wr(2'd0, 8'h13); tx_byte(8'h5A, 1, 1);
    wr(2'd0, 8'h03); tx_byte(8'hFF, 1, 0);

    // R5 fixed-rate mode ignores overflow inputs
    per[0] = 0; wr(2'd1, 8'h00); bit_clks = 32;
    wr(2'd0, 8'h02); tx_byte(8'hC3, 1, 0);
    wr(2'd1, 8'h10); bit_clks = 16; tx_byte(8'h81, 1, 0);

    // R6 source select and halving
    per[2] = 2; wr(2'd1, 8'h12); bit_clks = 32;
    wr(2'd0, 8'h01); tx_byte(8'h6B, 0, 0);
    per[2] = 0; per[0] = 1; wr(2'd1, 8'h00); tx_byte(8'h94, 0, 0);
    wr(2'd1, 8'h10); bit_clks = 16;

    // R11 collision
    exp_q.push_back({2'b00, 8'h11});
    wr(2'd2, 8'h11);
    repeat (20) @(negedge clk);
    wr(2'd2, 8'h22);
    rd(2'd1, v); chk("R11 collision flag", v[5], 1);
    repeat (13 * 16 + 40) @(negedge clk);
    chk("R11 single frame", exp_q.size(), 0);
    wr(2'd1, 8'h10);

    // R7 8-bit reception
    wr(2'd0, 8'h09);
    send(8'h4D, 0, 0, 1, -1);
    rd(2'd0, v); chk("R7 rx done", v[7], 1); chk("R7 stop to bit5", v[5], 1);
    rd(2'd2, v); chk("R7 rx data", v, 8'h4D);
    rd(2'd1, v); chk("R7 no frame error", v[7], 0);
    wr(2'd0, 8'h09);
    send(8'h12, 0, 0, 0, -1);
    rd(2'd0, v); chk("R7 low stop accepted", v[7], 1); chk("R7 low stop to bit5", v[5], 0);
    rd(2'd1, v); chk("R7 frame error", v[7], 1);
    rd(2'd2, v); chk("R7 data low stop", v, 8'h12);
    wr(2'd0, 8'h0D); wr(2'd1, 8'h10);
    send(8'h34, 0, 0, 0, -1);
    rd(2'd0, v); chk("R7 stop check rejects", v[7], 0);
    rd(2'd1, v); chk("R7 frame error w/ check", v[7], 1);
    rd(2'd2, v); chk("R7 buffer kept", v, 8'h12);
    wr(2'd1, 8'h10);

    // R10 overrun
    wr(2'd0, 8'h09);
    send(8'h55, 0, 0, 1, -1);
    send(8'h66, 0, 0, 1, -1);
    rd(2'd1, v); chk("R10 overrun set", v[6], 1);
    rd(2'd2, v); chk("R10 newest kept", v, 8'h66);
    wr(2'd1, 8'h10);
    send(8'h77, 0, 0, 1, -1);
    rd(2'd1, v); chk("R10 no overrun after read", v[6], 0);
    rd(2'd2, v);

    // R9 receiver disabled
    wr(2'd0, 8'h01);
    send(8'h99, 0, 0, 1, -1);
    rd(2'd0, v); chk("R9 no rx done", v[7], 0);
    rd(2'd2, v); chk("R9 buffer unchanged", v, 8'h77);

    // R8 multiprocessor filter, R4 ninth bit receive
    wr(2'd0, 8'h0F);
    send(8'hA1, 1, 0, 1, -1);
    rd(2'd0, v); chk("R8 ninth 0 rejected", v[7], 0);
    send(8'hA1, 1, 1, 1, -1);
    rd(2'd0, v); chk("R8 no match rejected", v[7], 0);
    match = 1'b1;
    send(8'hA1, 1, 1, 1, -1);
    rd(2'd0, v); chk("R8 match accepted", v[7], 1); chk("R4 rx ninth 1", v[5], 1);
    rd(2'd2, v); chk("R8 data", v, 8'hA1);
    match = 1'b0;
    wr(2'd0, 8'h0B);
    send(8'h3E, 1, 0, 1, -1);
    rd(2'd0, v); chk("R4 filter off accepts", v[7], 1); chk("R4 rx ninth 0", v[5], 0);
    rd(2'd2, v); chk("R4 data", v, 8'h3E);

    // R14 false start and glitch tolerance
    wr(2'd0, 8'h09);
    rxd = 1'b0; repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk("R14 false start", v[7], 0);
    send(8'hF0, 0, 0, 1, 6);
    send(8'hF0, 0, 0, 1, 2);
    rd(2'd2, v); chk("R14 glitch vote", v, 8'hF0);

    // R13 synchronous mode
    mon_on = 1'b0;
    wr(2'd0, 8'h08);
    txb = 8'hB2; rxb = 8'h6D;
    rxd = rxb[0];
    wr(2'd2, txb);
    for (int k = 0; k < 8; k++) begin
      chk("R13 sclk low", sclk, 0);
      chk("R13 txd bit", txd, txb[k]);
      @(negedge clk);
      chk("R13 sclk high", sclk, 1);
      if (k < 7) rxd = rxb[k+1];
      @(negedge clk);
    end
    chk("R13 done after 8th bit", irq, 1);
    rxd = 1'b1;
    rd(2'd0, v); chk("R13 tx done", v[6], 1); chk("R13 rx done", v[7], 1);
    rd(2'd2, v); chk("R13 rx byte", v, rxb);

    // R12 software control of flags
    wr(2'd0, 8'h08); chk("R12 irq clear", irq, 0);
    wr(2'd0, 8'h48); chk("R12 irq from tx done", irq, 1);
    wr(2'd0, 8'h08);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule